// File: doc/BRIEF.md
# Weekly Alarm and Seconds Interrupt Unit

This unit watches a running time of day and raises an alarm once a week-pattern match occurs. Software programs a target minute and hour, both in BCD, and a weekday mask in which each set bit picks one day of the week. On the seconds tick where the seconds field turns 00 and the minute, the hour and one of the masked days all agree, the alarm interrupt rises. The alarm resolution is therefore one minute. Because the target is a weekday pattern and not a date, it can lie at most one week ahead.

A second interrupt, enabled on its own, rises on any seconds tick. Driver software can use it to refine an alarm below the one-minute grain. Each interrupt is a level. It stays high until software clears its enable bit. A single write of zero to the control register silences both interrupts.

The counter that keeps the time is outside this unit. It presents the current seconds, minute and hour in BCD, a weekday index, and a one-cycle `tick` strobe in the cycle where those fields show the freshly advanced time.

Top module: `weekly_alarm`

## Requirements
- R1: After reset both interrupt outputs are low, both enables are clear, and the alarm minute, the alarm hour and the weekday mask are zero.
- R2: Writes use `wr_sel`: 0 = control (bit 4 alarm enable, bit 3 seconds enable), 1 = alarm minute (BCD), 2 = alarm hour (BCD), 3 = weekday mask. A tick with seconds 00, minute and hour equal to the stored values, the mask bit of the current weekday set, and the alarm enable set raises `irq_alarm` one cycle later.
- R3: A tick whose seconds field is not 00, or whose minute or hour differs from the stored value, does not raise `irq_alarm`.
- R4: Mask bit n selects weekday n, and several bits may be set at once. A weekday whose bit is clear, or a weekday index of 7 or above, never matches.
- R5: Once raised, `irq_alarm` stays high across later ticks that do not match. It falls one cycle after a control write that clears bit 4.
- R6: With bit 3 set, any tick raises `irq_sec` one cycle later, whatever the time fields hold. It stays high until a control write clears bit 3.
- R7: Writing zero to the control register drives both interrupts low one cycle later.
- R8: A tick is judged against the enables and alarm values held before that cycle. A write in the same cycle as a tick does not catch that tick. A clearing control write in the same cycle as a matching tick leaves the interrupt low.
- R9: Time fields that match the alarm raise nothing while `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle seconds strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday index |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_sec | output | 1 | Seconds interrupt, level |

## Verification
Two functions can fall on the same tick. The first is the minute-boundary alarm match and the seconds interrupt. With both enables set, the bench issues a matching tick at seconds 00 and expects both lines to rise together.

The second is a control write against a tick. The bench drives a control write and a matching tick in one cycle and judges the outcome by the rule in R8. When the write sets the enables, neither line rises. When the write clears the alarm enable and keeps the seconds enable, only `irq_sec` rises. An alarm-minute write that shares a cycle with a tick is likewise checked to take effect only from the next tick.

// File: rtl/weekly_alarm.sv
module weekly_alarm #(
  parameter int DAYS = 7,
  parameter int FW   = 8,
  parameter int WD_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [FW-1:0]   cur_sec,
  input  logic [FW-1:0]   cur_min,
  input  logic [FW-1:0]   cur_hour,
  input  logic [WD_W-1:0] cur_wday,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [((FW > DAYS) ? FW : DAYS)-1:0] wr_data,
  output logic            irq_alarm,
  output logic            irq_sec
);
  localparam int DW = (FW > DAYS) ? FW : DAYS;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MIN  = 2'd1;
  localparam logic [1:0] SEL_HOUR = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;
  localparam int ALM_BIT = 4;
  localparam int SEC_BIT = 3;

  logic            alm_en_q, sec_en_q;
  logic [FW-1:0]   alm_min_q, alm_hour_q;
  logic [DAYS-1:0] day_mask_q;
  logic            day_hit, hit;

  wire ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  wire alm_en_d = ctrl_wr ? wr_data[ALM_BIT] : alm_en_q;
  wire sec_en_d = ctrl_wr ? wr_data[SEC_BIT] : sec_en_q;

  always_comb begin
    day_hit = 1'b0;
    for (int i = 0; i < DAYS; i++)
      if (cur_wday == WD_W'(i) && day_mask_q[i]) day_hit = 1'b1;
  end

  assign hit = tick && alm_en_q && (cur_sec == '0) && (cur_min == alm_min_q)
               && (cur_hour == alm_hour_q) && day_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_en_q   <= 1'b0;
      sec_en_q   <= 1'b0;
      alm_min_q  <= '0;
      alm_hour_q <= '0;
      day_mask_q <= '0;
      irq_alarm  <= 1'b0;
      irq_sec    <= 1'b0;
    end else begin
      alm_en_q  <= alm_en_d;
      sec_en_q  <= sec_en_d;
      irq_alarm <= alm_en_d && (irq_alarm || hit);
      irq_sec   <= sec_en_d && (irq_sec || (tick && sec_en_q));
      if (wr_en && wr_sel == SEL_MIN)  alm_min_q  <= wr_data[FW-1:0];
      if (wr_en && wr_sel == SEL_HOUR) alm_hour_q <= wr_data[FW-1:0];
      if (wr_en && wr_sel == SEL_MASK) day_mask_q <= wr_data[DAYS-1:0];
    end
  end

  p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_alarm) |-> $past(tick));

  p_rise_on_zero_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_alarm) |-> $past(cur_sec) == '0);

  p_alarm_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_alarm && !(ctrl_wr && !wr_data[ALM_BIT])) |=> irq_alarm);

  p_sec_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sec && !(ctrl_wr && !wr_data[SEC_BIT])) |=> irq_sec);

  p_zero_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data == DW'(0)) |=> (!irq_alarm && !irq_sec));

  p_sec_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sec) |-> ($past(tick) && $past(sec_en_q)));
endmodule

// File: tb/weekly_alarm_tb_top.sv
module weekly_alarm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic irq_alarm, irq_sec;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  weekly_alarm dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_alarm(irq_alarm), .irq_sec(irq_sec));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tk(input logic [7:0] s, m, h, input logic [2:0] w);
    @(negedge clk); cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic tk_wr(input logic [7:0] s, m, h, input logic [2:0] w,
                       input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; tick = 1'b1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk(irq_alarm, 1'b0, "R1 alarm after reset");
    chk(irq_sec, 1'b0, "R1 sec after reset");
    tk(8'h00, 8'h00, 8'h00, 3'd0);
    chk(irq_alarm, 1'b0, "R1 zero regs, mask clear");
  endtask

  task automatic t_match;
    wr(2'd1, 8'h30); wr(2'd2, 8'h12); wr(2'd3, 8'h04); wr(2'd0, 8'h10);
    tk(8'h00, 8'h30, 8'h12, 3'd2);
    chk(irq_alarm, 1'b1, "R2 match raises alarm");
    chk(irq_sec, 1'b0, "R2 sec stays low");
    tk(8'h01, 8'h30, 8'h12, 3'd2);
    chk(irq_alarm, 1'b1, "R5 held on later tick");
    wr(2'd0, 8'h00);
    chk(irq_alarm, 1'b0, "R5 R7 cleared by ctrl write");
  endtask

  task automatic t_mismatch;
    wr(2'd0, 8'h10);
    tk(8'h01, 8'h30, 8'h12, 3'd2); chk(irq_alarm, 1'b0, "R3 nonzero seconds");
    tk(8'h00, 8'h31, 8'h12, 3'd2); chk(irq_alarm, 1'b0, "R3 minute mismatch");
    tk(8'h00, 8'h30, 8'h13, 3'd2); chk(irq_alarm, 1'b0, "R3 hour mismatch");
    @(negedge clk); cur_sec = 8'h00; cur_min = 8'h30; cur_hour = 8'h12; cur_wday = 3'd2;
    repeat (3) @(negedge clk);
    chk(irq_alarm, 1'b0, "R9 no tick no alarm");
  endtask

  task automatic t_days;
    wr(2'd3, 8'h41);
    tk(8'h00, 8'h30, 8'h12, 3'd2); chk(irq_alarm, 1'b0, "R4 unmasked day");
    tk(8'h00, 8'h30, 8'h12, 3'd6); chk(irq_alarm, 1'b1, "R4 day 6");
    wr(2'd0, 8'h00); wr(2'd0, 8'h10);
    tk(8'h00, 8'h30, 8'h12, 3'd0); chk(irq_alarm, 1'b1, "R4 day 0");
    wr(2'd0, 8'h00); wr(2'd3, 8'h7f); wr(2'd0, 8'h10);
    tk(8'h00, 8'h30, 8'h12, 3'd7); chk(irq_alarm, 1'b0, "R4 index 7 never matches");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_sec;
    wr(2'd0, 8'h08);
    chk(irq_sec, 1'b0, "R6 no tick yet");
    tk(8'h27, 8'h05, 8'h09, 3'd4);
    chk(irq_sec, 1'b1, "R6 any tick raises sec");
    chk(irq_alarm, 1'b0, "R6 alarm untouched");
    repeat (4) @(negedge clk);
    chk(irq_sec, 1'b1, "R6 sec held");
    wr(2'd0, 8'h00);
    chk(irq_sec, 1'b0, "R6 sec cleared");
  endtask

  task automatic t_collide;
    wr(2'd0, 8'h18);
    tk(8'h00, 8'h30, 8'h12, 3'd1);
    chk(irq_alarm, 1'b1, "R2 joint alarm");
    chk(irq_sec, 1'b1, "R6 joint sec");
    wr(2'd0, 8'h00);
    chk(irq_alarm, 1'b0, "R7 zero clears alarm");
    chk(irq_sec, 1'b0, "R7 zero clears sec");
    tk_wr(8'h00, 8'h30, 8'h12, 3'd1, 2'd0, 8'h18);
    chk(irq_alarm, 1'b0, "R8 enable same cycle misses alarm");
    chk(irq_sec, 1'b0, "R8 enable same cycle misses sec");
    tk_wr(8'h00, 8'h30, 8'h12, 3'd1, 2'd0, 8'h08);
    chk(irq_alarm, 1'b0, "R8 clear wins over hit");
    chk(irq_sec, 1'b1, "R8 sec kept");
    wr(2'd0, 8'h00); wr(2'd0, 8'h10);
    tk_wr(8'h00, 8'h30, 8'h12, 3'd1, 2'd1, 8'h45);
    chk(irq_alarm, 1'b1, "R8 old minute used");
    wr(2'd0, 8'h00); wr(2'd0, 8'h10);
    tk(8'h00, 8'h30, 8'h12, 3'd1);
    chk(irq_alarm, 1'b0, "R8 new minute in force");
  endtask

  initial begin
    #(5ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_mismatch();
    t_days();
    t_sec();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule